// File: doc/BRIEF.md
# Descriptor Ring Pointer and Interrupt Unit

This block keeps the pointer state for two circular descriptor rings of a copy engine: one ring that feeds the engine (source) and one it fills (destination). Software programs each ring's size as a power-of-two exponent and posts new work by moving the ring's write index through a small register port. The engine pulses a done line per ring whenever it finishes a descriptor, and the block moves that ring's read index forward modulo the ring size.

From the two indices the block derives a fill level per ring. It compares each level with a programmable pair of 16-bit thresholds. It rejects write-index updates that would lap the read index. It collects completion, watermark, overflow and engine-reported error events into two sticky status words. Each status bit is masked by its own enable bit, and the block drives a single interrupt line. A halt request freezes the read indices once the engine reports that nothing is in flight, and the halt status can be read back.

Top module: `dring_irq_unit`

## Requirements
- R1: After a synchronous reset every register reads 0. This covers sizes (exponent 0, one entry), indices, thresholds, enables, status and command. `irq` and `halted` are low.
- R2: A write to address 0 (source) or 1 (destination) loads the size exponent from bits 3:0 and clamps it to MAX_LOG2 (8). The same write returns both indices of that ring to 0. The ring then holds 2^exponent entries.
- R3: A write to address 2 (source) or 3 (destination) masks the data with (entries-1) and takes it as the new write index, unless R4 applies. The fill level at address 13 (source) or 14 (destination) equals (write - read) masked with (entries-1).
- R4: A write-index update is an overflow if its new fill level would be below the current one. An overflow leaves the index unchanged. It sets error status bit 5 (source) or bit 6 (destination) in the error status word at address 11.
- R5: A done pulse on a ring moves its read index (address 4 source, 5 destination) to (read+1) masked with (entries-1), but only when the fill level is nonzero. A done pulse on an empty ring is ignored. An accepted advance sets host status bit 0 (copy complete) at address 9.
- R6: The watermark word (address 6 source, 7 destination) carries the high threshold in bits 15:0. While a nonzero high threshold is below the fill level, host status bit 1 (source) or bit 3 (destination) is set.
- R7: The low threshold is in bits 31:16 of the same word. While a nonzero low threshold is above the fill level, host status bit 2 (source) or bit 4 (destination) is set.
- R8: The engine error inputs `eng_err[0..3]` set error status bits 7, 8, 9 and 10 respectively.
- R9: All status bits are sticky and clear on write-one at address 9 (host) or address 11 (error). When a set and a clear fall in the same cycle, the set wins.
- R10: `irq` is high exactly when a status bit is set together with its enable bit. Host enables are at address 8, bits 4:0. Error enables are at address 10, bits 10:5.
- R11: Address 12 holds the halt request in bit 0 and reads back the halt status in bit 3. Halt status rises one cycle after the request is seen with `eng_busy` low. It holds while the request stays set and falls one cycle after the request is cleared. While halted, done pulses do not move the read indices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the addressed register |
| src_done | input | 1 | Engine finished one source descriptor |
| dst_done | input | 1 | Engine finished one destination descriptor |
| eng_busy | input | 1 | A descriptor is in flight in the engine |
| eng_err | input | 4 | Engine error event pulses |
| irq | output | 1 | Interrupt, OR of enabled status bits |
| halted | output | 1 | Halt status |

## Verification
Register writes, index moves, overflow and copy-complete status, and `irq` all appear after the same rising edge that takes the stimulus, because read data and the interrupt are combinational from state. Watermark bits appear one edge later, since they are computed from the fill level that the previous edge registered. Halt status likewise follows its request by one edge. The bench steps a cycle model at every rising edge with the inputs driven in that cycle. It then compares the outputs and one randomly addressed register at the following falling edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int NRING  = 2;
    localparam int HOST_W = 5;
    localparam int ERR_W  = 6;
    localparam int ERR_LSB = 5;

    typedef enum logic [3:0] {
        A_SRC_SIZE = 4'd0,
        A_DST_SIZE = 4'd1,
        A_SRC_WIDX = 4'd2,
        A_DST_WIDX = 4'd3,
        A_SRC_RIDX = 4'd4,
        A_DST_RIDX = 4'd5,
        A_SRC_WM   = 4'd6,
        A_DST_WM   = 4'd7,
        A_HOST_IE  = 4'd8,
        A_HOST_IS  = 4'd9,
        A_ERR_IE   = 4'd10,
        A_ERR_IS   = 4'd11,
        A_CMD      = 4'd12,
        A_SRC_FILL = 4'd13,
        A_DST_FILL = 4'd14
    } reg_addr_e;

    typedef struct packed {
        logic ovf;
        logic adv;
        logic hi;
        logic lo;
    } ring_evt_t;

    function automatic int clamp_int(int v, int hi);
        return (v > hi) ? hi : v;
    endfunction

    function automatic logic wm_over(int level, logic [15:0] th);
        return (th != 16'd0) && (level > int'(th));
    endfunction

    function automatic logic wm_under(int level, logic [15:0] th);
        return (th != 16'd0) && (level < int'(th));
    endfunction

endpackage

// File: rtl/dring_ring.sv
module dring_ring
    import dring_pkg::*;
#(
    parameter int IW    = 8,
    parameter int LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             size_we,
    input  logic [LOG_W-1:0] size_in,
    input  logic             widx_we,
    input  logic [IW-1:0]    widx_in,
    input  logic             wm_we,
    input  logic [31:0]      wm_in,
    input  logic             done,
    input  logic             stall,
    output logic [LOG_W-1:0] size_q,
    output logic [IW-1:0]    widx_q,
    output logic [IW-1:0]    ridx_q,
    output logic [IW-1:0]    fill,
    output logic [31:0]      wm_q,
    output ring_evt_t        evt
);

    logic [IW:0]   one_sh;
    logic [IW-1:0] mask;
    logic [IW-1:0] wr_m;
    logic [IW-1:0] new_fill;

    always_comb begin
        one_sh   = (IW+1)'(1) << size_q;
        mask     = IW'(one_sh - 1'b1);
        fill     = (widx_q - ridx_q) & mask;
        wr_m     = widx_in & mask;
        new_fill = (wr_m - ridx_q) & mask;
        evt.ovf  = widx_we && (new_fill < fill);
        evt.adv  = done && !stall && (fill != '0);
        evt.hi   = wm_over(int'(fill), wm_q[15:0]);
        evt.lo   = wm_under(int'(fill), wm_q[31:16]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= '0;
            widx_q <= '0;
            ridx_q <= '0;
            wm_q   <= '0;
        end else begin
            if (size_we) begin
                size_q <= LOG_W'(clamp_int(int'(size_in), IW));
                widx_q <= '0;
                ridx_q <= '0;
            end else begin
                if (widx_we && !evt.ovf) widx_q <= wr_m;
                if (evt.adv)             ridx_q <= (ridx_q + 1'b1) & mask;
            end
            if (wm_we) wm_q <= wm_in;
        end
    end

endmodule

// File: rtl/dring_sticky.sv
module dring_sticky #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] en,
    output logic [W-1:0] q,
    output logic         hit
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~(clr_we ? clr : '0)) | set;
    end

    assign hit = |(q & en);

endmodule

// File: rtl/dring_irq_unit.sv
module dring_irq_unit
    import dring_pkg::*;
#(
    parameter int MAX_LOG2 = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        src_done,
    input  logic        dst_done,
    input  logic        eng_busy,
    input  logic [3:0]  eng_err,
    output logic        irq,
    output logic        halted
);

    localparam int IW    = MAX_LOG2;
    localparam int LOG_W = $clog2(MAX_LOG2 + 1);

    reg_addr_e a;
    assign a = reg_addr_e'(reg_addr);

    logic [NRING-1:0][LOG_W-1:0] ring_size;
    logic [NRING-1:0][IW-1:0]    ring_widx;
    logic [NRING-1:0][IW-1:0]    ring_ridx;
    logic [NRING-1:0][IW-1:0]    ring_fill;
    logic [NRING-1:0][31:0]      ring_wm;
    ring_evt_t [NRING-1:0]       ring_evt;
    logic [NRING-1:0]            ring_done;
    logic [NRING-1:0]            ring_ovf;

    logic              halt_req_q;
    logic              halted_q;
    logic [HOST_W-1:0] host_ie_q, host_is, host_set;
    logic [ERR_W-1:0]  err_ie_q, err_is, err_set;
    logic              host_hit, err_hit;

    assign ring_done = {dst_done, src_done};

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        logic size_we, widx_we, wm_we;
        assign size_we = reg_we && (a == ((g == 0) ? A_SRC_SIZE : A_DST_SIZE));
        assign widx_we = reg_we && (a == ((g == 0) ? A_SRC_WIDX : A_DST_WIDX));
        assign wm_we   = reg_we && (a == ((g == 0) ? A_SRC_WM   : A_DST_WM));

        dring_ring #(.IW(IW), .LOG_W(LOG_W)) u_ring (
            .clk     (clk),
            .rst     (rst),
            .size_we (size_we),
            .size_in (reg_wdata[LOG_W-1:0]),
            .widx_we (widx_we),
            .widx_in (reg_wdata[IW-1:0]),
            .wm_we   (wm_we),
            .wm_in   (reg_wdata),
            .done    (ring_done[g]),
            .stall   (halted_q),
            .size_q  (ring_size[g]),
            .widx_q  (ring_widx[g]),
            .ridx_q  (ring_ridx[g]),
            .fill    (ring_fill[g]),
            .wm_q    (ring_wm[g]),
            .evt     (ring_evt[g])
        );
        assign ring_ovf[g] = ring_evt[g].ovf;
    end

    assign host_set = {ring_evt[1].lo, ring_evt[1].hi, ring_evt[0].lo, ring_evt[0].hi,
                       ring_evt[0].adv | ring_evt[1].adv};
    assign err_set  = {eng_err, ring_ovf[1], ring_ovf[0]};

    dring_sticky #(.W(HOST_W)) u_host (
        .clk    (clk),
        .rst    (rst),
        .set    (host_set),
        .clr_we (reg_we && (a == A_HOST_IS)),
        .clr    (reg_wdata[HOST_W-1:0]),
        .en     (host_ie_q),
        .q      (host_is),
        .hit    (host_hit)
    );

    dring_sticky #(.W(ERR_W)) u_err (
        .clk    (clk),
        .rst    (rst),
        .set    (err_set),
        .clr_we (reg_we && (a == A_ERR_IS)),
        .clr    (reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB]),
        .en     (err_ie_q),
        .q      (err_is),
        .hit    (err_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_ie_q  <= '0;
            err_ie_q   <= '0;
            halt_req_q <= 1'b0;
            halted_q   <= 1'b0;
        end else begin
            if (reg_we && a == A_HOST_IE) host_ie_q  <= reg_wdata[HOST_W-1:0];
            if (reg_we && a == A_ERR_IE)  err_ie_q   <= reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB];
            if (reg_we && a == A_CMD)     halt_req_q <= reg_wdata[0];
            halted_q <= halt_req_q && (halted_q || !eng_busy);
        end
    end

    assign irq    = host_hit | err_hit;
    assign halted = halted_q;

    always_comb begin
        case (a)
            A_SRC_SIZE: reg_rdata = 32'(ring_size[0]);
            A_DST_SIZE: reg_rdata = 32'(ring_size[1]);
            A_SRC_WIDX: reg_rdata = 32'(ring_widx[0]);
            A_DST_WIDX: reg_rdata = 32'(ring_widx[1]);
            A_SRC_RIDX: reg_rdata = 32'(ring_ridx[0]);
            A_DST_RIDX: reg_rdata = 32'(ring_ridx[1]);
            A_SRC_WM:   reg_rdata = ring_wm[0];
            A_DST_WM:   reg_rdata = ring_wm[1];
            A_HOST_IE:  reg_rdata = 32'(host_ie_q);
            A_HOST_IS:  reg_rdata = 32'(host_is);
            A_ERR_IE:   reg_rdata = 32'(err_ie_q) << ERR_LSB;
            A_ERR_IS:   reg_rdata = 32'(err_is) << ERR_LSB;
            A_CMD:      reg_rdata = {28'd0, halted_q, 2'b00, halt_req_q};
            A_SRC_FILL: reg_rdata = 32'(ring_fill[0]);
            A_DST_FILL: reg_rdata = 32'(ring_fill[1]);
            default:    reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
    parameter int IW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               irq,
    input logic               halted,
    input logic               src_done,
    input logic               halt_req,
    input logic [4:0]         host_ie,
    input logic [5:0]         err_ie,
    input logic [1:0][IW-1:0] ridx,
    input logic [1:0][IW-1:0] widx,
    input logic [1:0][IW-1:0] fill,
    input logic [1:0]         ovf
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !halted));

    // R4
    src_ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf[0] |=> (widx[0] == $past(widx[0])));

    // R4
    dst_ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf[1] |=> (widx[1] == $past(widx[1])));

    // R5
    empty_done_chk: assert property (@(posedge clk) disable iff (rst)
        (src_done && fill[0] == '0) |=> (ridx[0] == $past(ridx[0]) || ridx[0] == '0));

    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (ridx[0] == $past(ridx[0]) || ridx[0] == '0));

    // R11
    halt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> $past(halt_req));

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ie == '0 && err_ie == '0) |-> !irq);

endmodule

bind dring_irq_unit dring_chk #(.IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .halted   (halted),
    .src_done (src_done),
    .halt_req (halt_req_q),
    .host_ie  (host_ie_q),
    .err_ie   (err_ie_q),
    .ridx     (ring_ridx),
    .widx     (ring_widx),
    .fill     (ring_fill),
    .ovf      (ring_ovf)
);

// File: tb/sim_dring_irq_unit.sv
module sim_dring_irq_unit;

    localparam int MAXL = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        src_done, dst_done, eng_busy;
    logic [3:0]  eng_err;
    logic        irq, halted;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dring_irq_unit #(.MAX_LOG2(MAXL)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_done(src_done),
        .dst_done(dst_done), .eng_busy(eng_busy), .eng_err(eng_err),
        .irq(irq), .halted(halted)
    );

    // cycle model state
    int unsigned m_log[2], m_w[2], m_r[2];
    logic [31:0] m_wm[2];
    logic [4:0]  m_hie, m_his;
    logic [5:0]  m_eie, m_eis;
    bit          m_hreq, m_halt;

    function automatic int unsigned fmask(int unsigned l);
        return (32'd1 << l) - 1;
    endfunction

    function automatic int unsigned ffill(int i);
        return (m_w[i] - m_r[i]) & fmask(m_log[i]);
    endfunction

    function automatic logic [31:0] mread(int ad);
        case (ad)
            0: return m_log[0];
            1: return m_log[1];
            2: return m_w[0];
            3: return m_w[1];
            4: return m_r[0];
            5: return m_r[1];
            6: return m_wm[0];
            7: return m_wm[1];
            8: return 32'(m_hie);
            9: return 32'(m_his);
            10: return 32'(m_eie) << 5;
            11: return 32'(m_eis) << 5;
            12: return (32'(m_halt) << 3) | 32'(m_hreq);
            13: return ffill(0);
            14: return ffill(1);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rtag(int ad);
        case (ad)
            0, 1: return "R2";
            2, 3, 13, 14: return "R3";
            4, 5: return "R5";
            6, 7: return "R6";
            8, 9: return "R9";
            10, 11: return "R8";
            12: return "R11";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(int ad, output logic [31:0] v);
        reg_addr = ad[3:0];
        #1;
        v = reg_rdata;
    endtask

    // one clock: drive inputs, advance the model, compare at the falling edge
    task automatic step(bit we, int ad, logic [31:0] wd, bit sd, bit dd, bit busy, logic [3:0] er);
        bit dn[2];
        int unsigned nl[2], nw[2], nr[2];
        logic [31:0] nwm[2];
        bit adv[2], ovf[2], hi[2], lo[2];
        logic [4:0] hset, his_n, hie_n;
        logic [5:0] eset, eis_n, eie_n;
        bit hreq_n, halt_n;
        logic [31:0] v;
        int ra;
        reg_we = we; reg_addr = ad[3:0]; reg_wdata = wd;
        src_done = sd; dst_done = dd; eng_busy = busy; eng_err = er;
        dn[0] = sd; dn[1] = dd;
        for (int i = 0; i < 2; i++) begin
            int unsigned mk, f, wmsk, nf;
            mk = fmask(m_log[i]);
            f  = ffill(i);
            adv[i] = dn[i] && !m_halt && f != 0;
            hi[i]  = m_wm[i][15:0] != 0 && f > m_wm[i][15:0];
            lo[i]  = m_wm[i][31:16] != 0 && f < m_wm[i][31:16];
            ovf[i] = 0;
            nl[i] = m_log[i]; nw[i] = m_w[i];
            nr[i] = adv[i] ? ((m_r[i] + 1) & mk) : m_r[i];
            nwm[i] = (we && ad == 6 + i) ? wd : m_wm[i];
            if (we && ad == i) begin
                nl[i] = (wd[3:0] > MAXL) ? MAXL : wd[3:0];
                nw[i] = 0; nr[i] = 0;
            end
            if (we && ad == 2 + i) begin
                wmsk = wd & mk;
                nf = (wmsk - m_r[i]) & mk;
                if (nf < f) ovf[i] = 1;
                else nw[i] = wmsk;
            end
        end
        hset = {lo[1], hi[1], lo[0], hi[0], adv[0] | adv[1]};
        eset = {er, ovf[1], ovf[0]};
        his_n = ((we && ad == 9) ? (m_his & ~wd[4:0]) : m_his) | hset;
        eis_n = ((we && ad == 11) ? (m_eis & ~wd[10:5]) : m_eis) | eset;
        hie_n = (we && ad == 8) ? wd[4:0] : m_hie;
        eie_n = (we && ad == 10) ? wd[10:5] : m_eie;
        hreq_n = (we && ad == 12) ? wd[0] : m_hreq;
        halt_n = m_hreq && (m_halt || !busy);
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            m_log[i] = nl[i]; m_w[i] = nw[i]; m_r[i] = nr[i]; m_wm[i] = nwm[i];
        end
        m_his = his_n; m_eis = eis_n; m_hie = hie_n; m_eie = eie_n;
        m_hreq = hreq_n; m_halt = halt_n;
        @(negedge clk);
        reg_we = 0; src_done = 0; dst_done = 0; eng_err = '0;
        // R10 interrupt level
        chk("R10 irq", 32'(irq), 32'(|(m_his & m_hie) | |(m_eis & m_eie)));
        // R11 halt output
        chk("R11 halted", 32'(halted), 32'(m_halt));
        ra = $urandom_range(0, 15);
        rd(ra, v);
        chk(rtag(ra), v, mread(ra));
    endtask

    task automatic wr(int ad, logic [31:0] wd);
        step(1, ad, wd, 0, 0, 0, 4'd0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        rst = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        src_done = 0; dst_done = 0; eng_busy = 0; eng_err = 0;
        for (int i = 0; i < 2; i++) begin
            m_log[i] = 0; m_w[i] = 0; m_r[i] = 0; m_wm[i] = 0;
        end
        m_hie = 0; m_his = 0; m_eie = 0; m_eis = 0; m_hreq = 0; m_halt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        for (int ad = 0; ad < 16; ad++) begin
            rd(ad, v);
            chk("R1 reset reg", v, 32'd0);
        end
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 halted", 32'(halted), 32'd0);

        // R2 / R3 / R4 on the source ring
        wr(0, 32'd3);
        wr(2, 32'd5);
        rd(13, v); chk("R3 fill", v, 32'd5);
        wr(2, 32'd2);
        rd(11, v); chk("R4 src overflow bit", v, 32'h20);
        rd(2, v);  chk("R4 index kept", v, 32'd5);
        wr(2, 32'd15);
        rd(2, v);  chk("R3 masked index", v, 32'd7);
        wr(2, 32'd0);
        rd(2, v);  chk("R4 lap rejected", v, 32'd7);

        // R5 advance and copy complete
        for (int k = 0; k < 3; k++) step(0, 15, 0, 1, 0, 0, 4'd0);
        rd(4, v);  chk("R5 read index", v, 32'd3);
        rd(9, v);  chk("R5 copy complete", v & 32'h1, 32'h1);

        // R2 clamp and index clear
        wr(0, 32'd12);
        rd(0, v);  chk("R2 clamp", v, 32'd8);
        rd(2, v);  chk("R2 index clear", v, 32'd0);
        step(0, 15, 0, 1, 0, 0, 4'd0);
        rd(4, v);  chk("R5 empty ignored", v, 32'd0);

        // R6 / R7 watermarks on the destination ring
        wr(1, 32'd4);
        wr(3, 32'd10);
        wr(7, {16'd12, 16'd5});
        step(0, 15, 0, 0, 0, 0, 4'd0);
        rd(9, v);  chk("R6 R7 dst watermarks", v & 32'h18, 32'h18);
        wr(7, 32'd0);
        wr(9, 32'h1f);
        rd(9, v);  chk("R9 cleared", v, 32'd0);
        wr(11, 32'h7e0);
        rd(11, v); chk("R9 err cleared", v, 32'd0);

        // R10 enable and copy complete
        wr(8, 32'h1);
        chk("R10 no irq", 32'(irq), 32'd0);
        step(0, 15, 0, 0, 1, 0, 4'd0);
        chk("R10 irq set", 32'(irq), 32'd1);
        // R9 set wins over clear
        step(1, 9, 32'h1, 0, 1, 0, 4'd0);
        rd(9, v);  chk("R9 set wins", v & 32'h1, 32'h1);

        // R8 engine errors
        step(0, 15, 0, 0, 0, 0, 4'b1010);
        rd(11, v); chk("R8 error bits", v, 32'h500);

        // R11 halt handshake
        step(1, 12, 32'd1, 0, 0, 1, 4'd0);
        step(0, 15, 0, 0, 0, 1, 4'd0);
        chk("R11 busy holds off", 32'(halted), 32'd0);
        step(0, 15, 0, 0, 0, 0, 4'd0);
        chk("R11 halted", 32'(halted), 32'd1);
        rd(5, v);
        step(0, 15, 0, 0, 1, 1, 4'd0);
        begin
            logic [31:0] v2;
            rd(5, v2); chk("R11 frozen index", v2, v);
        end
        rd(12, v); chk("R11 status bit", v, 32'h9);
        wr(12, 32'd0);
        step(0, 15, 0, 0, 0, 0, 4'd0);
        chk("R11 released", 32'(halted), 32'd0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int sel, ad;
            logic [31:0] wd;
            bit we;
            sel = $urandom_range(0, 99);
            we = 1; wd = $urandom;
            if (sel < 2)       begin ad = $urandom_range(0, 1); wd = $urandom_range(0, 10); end
            else if (sel < 30) begin ad = $urandom_range(2, 3); wd = m_w[ad-2] + $urandom_range(0, 6); end
            else if (sel < 36) begin ad = $urandom_range(6, 7);
                                     wd = {16'($urandom_range(0, 20)), 16'($urandom_range(0, 20))}; end
            else if (sel < 40) ad = 8;
            else if (sel < 46) ad = 9;
            else if (sel < 49) ad = 10;
            else if (sel < 54) ad = 11;
            else if (sel < 57) begin ad = 12; wd = 32'($urandom_range(0, 1)); end
            else begin we = 0; ad = 15; end
            step(we, ad, wd, ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
                 ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'd0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule